// File: doc/BRIEF.md
# Paired I/Q Input Sample Queue with Almost-Empty Threshold

This block buffers the in-phase and quadrature input samples of one transmit channel in two matched queues that share a single write pointer, a single read pointer and a single fill counter, so an I sample and its Q partner always enter and leave together. A parallel source writes one I/Q pair per cycle. The filter side sees the oldest pair at the head of the queue and advances it with a read strobe.

A single 3-bit threshold, coded as the fill level minus one, controls a registered almost-empty flag that covers both queues. A data-request output asks the source for more samples while the flag is set and transmit-enable is high. An off-line control holds the pointers at zero so that the read side returns zero samples.

Writing into a full queue is an overflow. In parallel input mode, unless a disable bit is set, an overflow clears the queue and emits a one-cycle channel-reset pulse.

Top module: `iq_sample_fifo`

## Requirements
- R1: Once synchronous active-low reset has been applied, the queue is empty, rd_i and rd_q read zero, almost_empty is 1 and ovf_rst is 0.
- R2: While online is 1, I/Q pairs leave in the order they were written. rd_i and rd_q show the oldest stored pair combinationally, and rd_en with a non-empty queue removes that pair at the next clock edge. The queue holds DEPTH pairs.
- R3: almost_empty is a register. After each clock edge it equals 1 when the fill level just stored is less than or equal to thresh+1, where thresh is the 3-bit value present at that edge. Both the I and the Q queue use this one flag.
- R4: While online is 0, the pointers and the fill level are forced to zero at each edge, writes and reads have no effect, and rd_i and rd_q read zero.
- R5: With par_mode=1 and ovf_rst_dis=0, a write into a full queue without a read in the same cycle empties the queue at that edge. ovf_rst is then 1 for exactly the following cycle.
- R6: With par_mode=0 or ovf_rst_dis=1, a write into a full queue without a read is dropped. The stored pairs are kept and ovf_rst stays 0.
- R7: When the queue is full, a write and a read in the same cycle both take effect. The fill level stays at DEPTH and no overflow is raised.
- R8: data_req equals online AND tx_en AND almost_empty.
- R9: rd_en on an empty queue has no effect: the next written pair is still the first one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| online | input | 1 | 1 = normal queue operation, 0 = off-line (cleared, reads zero) |
| par_mode | input | 1 | 1 = parallel input mode, in which overflow can reset the channel |
| ovf_rst_dis | input | 1 | 1 = suppress the overflow channel reset |
| tx_en | input | 1 | Transmit-enable level that gates data requests |
| thresh | input | THR_W | Almost-empty threshold, coded as fill level minus one |
| wr_en | input | 1 | Write strobe for one I/Q pair |
| wr_i | input | DATA_W | In-phase sample to write |
| wr_q | input | DATA_W | Quadrature sample to write |
| rd_en | input | 1 | Remove the head pair |
| rd_i | output | DATA_W | In-phase head sample, or zero |
| rd_q | output | DATA_W | Quadrature head sample, or zero |
| almost_empty | output | 1 | Registered almost-empty flag |
| data_req | output | 1 | Request for more input samples |
| ovf_rst | output | 1 | One-cycle channel-reset pulse after an overflow |

## Verification
The bench builds the block with its defaults: DATA_W=16, DEPTH=8 and a 3-bit threshold. With these values every threshold code can be reached, and code 7 puts the flag limit equal to the full depth, so the flag never drops. Because the depth is only eight, random traffic fills the queue often. Full-queue writes therefore come up under every combination of parallel mode and disable bit, alongside directed fills, drains and off-line periods.

// File: rtl/iqf_pkg.sv
// Package for the paired I/Q sample queue.
// Holds the per-cycle decision record that the pointer controller hands to
// the storage lanes and the flag logic.
package iqf_pkg;

    // Result of one cycle's control decision.
    typedef struct packed {
        logic flush;  // clear pointers and fill level at this edge
        logic push;   // store one I/Q pair
        logic pop;    // retire the head pair
    } iqf_step_t;

endpackage

// File: rtl/iqf_ptr_ctrl.sv
// Shared pointer and fill-level controller for the I and Q queues.
// Decides each cycle whether to push, pop or flush, and raises the overflow
// channel-reset pulse. Assumes DEPTH >= 2 and that one write and one read
// strobe drive both lanes.
module iqf_ptr_ctrl
    import iqf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             online,
    input  logic             par_mode,
    input  logic             ovf_rst_dis,
    input  logic             wr_en,
    input  logic             rd_en,
    output iqf_step_t        step,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             ovf_rst
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic is_empty;
    logic is_full;
    logic ovf_evt;
    logic ovf_trip;

    // Wrap-around increment for a queue pointer.
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Per-cycle decision: pop, push, overflow and flush.
    always_comb begin
        is_empty   = (count == '0);
        is_full    = (count == FULL_LVL);
        step.pop   = online && rd_en && !is_empty;
        step.push  = online && wr_en && (!is_full || step.pop);
        ovf_evt    = online && wr_en && is_full && !step.pop;
        ovf_trip   = ovf_evt && par_mode && !ovf_rst_dis;
        step.flush = !online || ovf_trip;
        if (step.flush) begin
            step.push = 1'b0;
            step.pop  = 1'b0;
        end
    end

    // Fill level that the coming edge will store.
    always_comb begin
        if (step.flush) begin
            count_nxt = '0;
        end else begin
            case ({step.push, step.pop})
                2'b10:   count_nxt = count + 1'b1;
                2'b01:   count_nxt = count - 1'b1;
                default: count_nxt = count;
            endcase
        end
    end

    // Pointer, fill-level and overflow-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            ovf_rst <= 1'b0;
        end else begin
            ovf_rst <= ovf_trip;
            count   <= count_nxt;
            if (step.flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (step.push) wr_ptr <= ptr_inc(wr_ptr);
                if (step.pop)  rd_ptr <= ptr_inc(rd_ptr);
            end
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_LVL);

    assert_offline_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !online |=> (count == '0) && (rd_ptr == '0) && (wr_ptr == '0));

    assert_ovf_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_rst |=> !ovf_rst);

    assert_ovf_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode || ovf_rst_dis) |=> !ovf_rst);

    assert_full_rw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (online && is_full && wr_en && rd_en) |=> (count == FULL_LVL) && !ovf_rst);

endmodule

// File: rtl/iqf_store.sv
// One storage lane (I or Q) of the sample queue.
// Writes at the shared write pointer and shows the entry at the shared read
// pointer without a register stage. Holds no reset: contents are valid only
// where the controller's fill level says so.
module iqf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one sample at the write pointer.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the head sample.
    assign rdata = mem[raddr];

endmodule

// File: rtl/iqf_flags.sv
// Almost-empty flag and data-request gate shared by both lanes.
// The flag is registered from the fill level being stored at the same edge,
// compared against the threshold plus one. Requests need on-line mode and
// transmit-enable high.
module iqf_flags #(
    parameter int CNT_W = 4,
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic [THR_W-1:0] thresh,
    input  logic             online,
    input  logic             tx_en,
    output logic             almost_empty,
    output logic             data_req
);

    localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

    logic [CMP_W-1:0] limit;
    logic [CMP_W-1:0] level;

    // Threshold is coded as level minus one, so widen and add one.
    assign limit = CMP_W'(thresh) + 1'b1;
    assign level = CMP_W'(count_nxt);

    // Registered almost-empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) almost_empty <= 1'b1;
        else        almost_empty <= (level <= limit);
    end

    // Request more samples when low on data and transmit is enabled.
    assign data_req = online && tx_en && almost_empty;

endmodule

// File: rtl/iq_sample_fifo.sv
// Paired I/Q input sample queue for one transmit channel.
// Two storage lanes share one pointer controller, so I and Q stay aligned.
// Read outputs are forced to zero when off-line or empty. Assumes one
// parallel write port and one read strobe from the filter.
module iq_sample_fifo
    import iqf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int THR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              online,
    input  logic              par_mode,
    input  logic              ovf_rst_dis,
    input  logic              tx_en,
    input  logic [THR_W-1:0]  thresh,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_i,
    input  logic [DATA_W-1:0] wr_q,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_i,
    output logic [DATA_W-1:0] rd_q,
    output logic              almost_empty,
    output logic              data_req,
    output logic              ovf_rst
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LANES = 2;

    iqf_step_t                      step;
    logic [PTR_W-1:0]               wr_ptr;
    logic [PTR_W-1:0]               rd_ptr;
    logic [CNT_W-1:0]               count;
    logic [CNT_W-1:0]               count_nxt;
    logic [LANES-1:0][DATA_W-1:0]   lane_wr;
    logic [LANES-1:0][DATA_W-1:0]   lane_rd;
    logic                           head_ok;

    iqf_ptr_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .online      (online),
        .par_mode    (par_mode),
        .ovf_rst_dis (ovf_rst_dis),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .step        (step),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .count       (count),
        .count_nxt   (count_nxt),
        .ovf_rst     (ovf_rst)
    );

    // Lane 0 carries I, lane 1 carries Q.
    assign lane_wr = {wr_q, wr_i};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        iqf_store #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .PTR_W  (PTR_W)
        ) u_store (
            .clk   (clk),
            .we    (step.push),
            .waddr (wr_ptr),
            .wdata (lane_wr[g]),
            .raddr (rd_ptr),
            .rdata (lane_rd[g])
        );
    end

    iqf_flags #(
        .CNT_W (CNT_W),
        .THR_W (THR_W)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_nxt    (count_nxt),
        .thresh       (thresh),
        .online       (online),
        .tx_en        (tx_en),
        .almost_empty (almost_empty),
        .data_req     (data_req)
    );

    // Zero the read side when off-line or when nothing is stored.
    assign head_ok = online && (count != '0);
    assign rd_i    = head_ok ? lane_rd[0] : '0;
    assign rd_q    = head_ok ? lane_rd[1] : '0;

    assert_ovf_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_rst |-> almost_empty && (rd_i == '0) && (rd_q == '0));

    assert_req_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!online || !tx_en) |-> !data_req);

endmodule

// File: tb/iq_sample_fifo_tb_top.sv
module iq_sample_fifo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int DEPTH      = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          online, par_mode, ovf_rst_dis, tx_en, wr_en, rd_en;
    logic [2:0]    thresh;
    logic [DW-1:0] wr_i, wr_q, rd_i, rd_q;
    logic          almost_empty, data_req, ovf_rst;

    int            n_chk = 0;
    int            n_err = 0;
    logic [DW-1:0] qi[$];
    logic [DW-1:0] qq[$];
    logic          ae_exp;
    logic          ovf_exp;
    string         ovf_tag;
    string         rd_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iq_sample_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .online(online), .par_mode(par_mode),
        .ovf_rst_dis(ovf_rst_dis), .tx_en(tx_en), .thresh(thresh),
        .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q), .rd_en(rd_en),
        .rd_i(rd_i), .rd_q(rd_q), .almost_empty(almost_empty),
        .data_req(data_req), .ovf_rst(ovf_rst)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_ae(input int sz, input logic [2:0] t);
        return sz <= int'(t) + 1;
    endfunction

    function automatic logic [DW-1:0] exp_head(input logic on, input logic q_sel);
        if (!on || qi.size() == 0) return '0;
        return q_sel ? qq[0] : qi[0];
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Compare every output with the model state of this cycle.
    task automatic check_now();
        chk(online ? rd_tag : "R4", "rd_i", 32'(rd_i), 32'(exp_head(online, 1'b0)));
        chk(online ? rd_tag : "R4", "rd_q", 32'(rd_q), 32'(exp_head(online, 1'b1)));
        chk("R3", "almost_empty", 32'(almost_empty), 32'(ae_exp));
        chk(ovf_tag, "ovf_rst", 32'(ovf_rst), 32'(ovf_exp));
        chk("R8", "data_req", 32'(data_req), 32'(online && tx_en && ae_exp));
    endtask

    // Apply this cycle's inputs to the model, as the next edge will.
    task automatic model_step();
        bit do_rd, do_wr, ovf;
        ovf_exp = 1'b0;
        ovf_tag = "R5";
        if (!online) begin
            qi.delete();
            qq.delete();
        end else begin
            do_rd = rd_en && qi.size() > 0;
            do_wr = wr_en && (qi.size() < DEPTH || do_rd);
            ovf   = wr_en && qi.size() == DEPTH && !do_rd;
            if (wr_en && rd_en && qi.size() == DEPTH) ovf_tag = "R7";
            if (ovf && par_mode && !ovf_rst_dis) begin
                qi.delete();
                qq.delete();
                ovf_exp = 1'b1;
            end else begin
                if (ovf) ovf_tag = "R6";
                if (do_rd) begin
                    void'(qi.pop_front());
                    void'(qq.pop_front());
                end
                if (do_wr) begin
                    qi.push_back(wr_i);
                    qq.push_back(wr_q);
                end
            end
        end
        ae_exp = exp_ae(qi.size(), thresh);
    endtask

    // Inputs are set at the falling edge; check, advance model, wait.
    task automatic cycle();
        #1;
        check_now();
        model_step();
        @(negedge clk);
    endtask

    task automatic drive(input logic w, input logic r);
        wr_en = w;
        rd_en = r;
        wr_i  = DW'($urandom);
        wr_q  = DW'($urandom);
        cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h1D5E_0217));
        rst_n = 1'b0; online = 1'b1; par_mode = 1'b1; ovf_rst_dis = 1'b0;
        tx_en = 1'b1; thresh = 3'd2; wr_en = 1'b0; rd_en = 1'b0;
        wr_i = '0; wr_q = '0;
        ae_exp = 1'b1; ovf_exp = 1'b0; ovf_tag = "R5"; rd_tag = "R2";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "rd_i", 32'(rd_i), 32'h0);
        chk("R1", "rd_q", 32'(rd_q), 32'h0);
        chk("R1", "almost_empty", 32'(almost_empty), 32'h1);
        chk("R1", "ovf_rst", 32'(ovf_rst), 32'h0);

        // R2 / R3: fill to full, then R5: overflow resets channel
        for (int k = 0; k < DEPTH; k++) drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);

        // R6: overflow with disable bit, then in serial mode
        for (int k = 0; k < DEPTH; k++) drive(1'b1, 1'b0);
        ovf_rst_dis = 1'b1;
        drive(1'b1, 1'b0);
        ovf_rst_dis = 1'b0; par_mode = 1'b0;
        drive(1'b1, 1'b0);
        par_mode = 1'b1;
        drive(1'b0, 1'b0);

        // R7: full with simultaneous read and write
        for (int k = 0; k < 4; k++) drive(1'b1, 1'b1);

        // R9: drain, read while empty, then a fresh write heads the queue
        for (int k = 0; k < DEPTH; k++) drive(1'b0, 1'b1);
        rd_tag = "R9";
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        rd_tag = "R2";

        // R4: off-line clears and ignores traffic
        for (int k = 0; k < 4; k++) drive(1'b1, 1'b0);
        online = 1'b0;
        for (int k = 0; k < 4; k++) drive(1'b1, k[0]);
        online = 1'b1;
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);

        // R3: sweep every threshold code through fill and drain
        for (int t = 0; t < 8; t++) begin
            thresh = 3'(t);
            for (int k = 0; k < DEPTH; k++) drive(1'b1, 1'b0);
            for (int k = 0; k < DEPTH; k++) drive(1'b0, 1'b1);
        end

        // Random traffic over all control combinations
        for (int n = 0; n < 4000; n++) begin
            if (n % 23 == 0) thresh = 3'($urandom_range(0, 7));
            online      = ($urandom_range(0, 99) < 96);
            par_mode    = ($urandom_range(0, 99) < 75);
            ovf_rst_dis = ($urandom_range(0, 99) < 25);
            tx_en       = ($urandom_range(0, 99) < 70);
            drive($urandom_range(0, 99) < 60, $urandom_range(0, 99) < 45);
        end
        summary();
    end

endmodule